// File: doc/BRIEF.md
# MMU Exception Entry Sequencer

This block carries out the fixed hardware work of taking a memory-management exception. When a request arrives with a cause kind, it saves in a single clock edge everything the software handler will need: the page-number part of the faulting address, the whole faulting address, a cause code, the return PC, the old status word and the TLB way that faulted. In the same cycle it sets the privilege, block and register-bank bits of the status word and redirects fetch to the handler at the vector base plus an offset chosen by the cause kind.

The status register itself lives outside the block. The block reads it on `sr_i` and writes it back through `sr_we_o` and `sr_next_o`, so the owner of that register must take the write on the same edge as the redirect. A return input reverses the entry: it writes the saved status word back and redirects fetch to the saved PC.

A return and a request in the same cycle resolve as a return. A request that arrives while the block bit of the status word is already set is dropped.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, `vpn_o`, `tea_o`, `spc_o`, `ssr_o`, `cause_o` and `rc_o` are all zero. While no request or return is present, `redirect_o` and `sr_we_o` are low.
- R2: A request is accepted when `exc_req_i` is 1, `rte_i` is 0 and `sr_i[28]` is 0. On the clock edge that takes an accepted request, `tea_o` loads `fault_va_i` and `vpn_o` loads `fault_va_i[31:10]`.
- R3: An accepted request loads a cause code into `cause_o` according to `exc_kind_i`: 0 (initial page write) gives 0x080, 1 (miss on read) gives 0x040, 2 (miss on write) gives 0x060, and 3 (protection) gives 0x0A0.
- R4: An accepted request loads `spc_o` with `pc_i` when `in_dslot_i` is 0, and with `branch_pc_i` when `in_dslot_i` is 1.
- R5: An accepted request loads `ssr_o` with `sr_i`. In the same cycle `sr_we_o` is 1 and `sr_next_o` equals `sr_i` with bit 30 (privilege), bit 29 (register bank) and bit 28 (block) set to 1.
- R6: An accepted request loads `rc_o` with `way_i`.
- R7: In the cycle an accepted request is present, `redirect_o` is 1 and `target_o` equals `vbr_i` plus the offset, computed modulo 2^32. The offset is 0x100 for kinds 0 and 3 and 0x400 for kinds 1 and 2.
- R8: A request with `sr_i[28]` at 1 and `rte_i` at 0 is ignored. `redirect_o` and `sr_we_o` stay low, and all saved registers keep their values.
- R9: When `rte_i` is 1, whether or not a request is present, the block does three things in that cycle: it drives `redirect_o` to 1, drives `target_o` to the value of `spc_o`, and drives `sr_we_o` to 1 with `sr_next_o` equal to `ssr_o`. The saved registers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_req_i | input | 1 | Exception request |
| exc_kind_i | input | 2 | Cause kind of the request |
| fault_va_i | input | 32 | Faulting virtual address |
| pc_i | input | 32 | Address of the faulting instruction |
| in_dslot_i | input | 1 | Fault occurred in a delay slot |
| branch_pc_i | input | 32 | Address of the delayed branch that owns the slot |
| sr_i | input | 32 | Current status register |
| vbr_i | input | 32 | Vector base |
| way_i | input | 2 | TLB way that faulted |
| rte_i | input | 1 | Return from exception |
| redirect_o | output | 1 | Fetch redirect strobe |
| target_o | output | 32 | Redirect target address |
| sr_we_o | output | 1 | Status register write enable |
| sr_next_o | output | 32 | Status register write value |
| vpn_o | output | 22 | Saved page number field |
| tea_o | output | 32 | Saved fault address |
| spc_o | output | 32 | Saved return PC |
| ssr_o | output | 32 | Saved status word |
| cause_o | output | 12 | Saved cause code |
| rc_o | output | 2 | Saved faulting way |

## Verification
The assertions assume three things about the inputs: `sr_i` reflects the value written back through `sr_we_o` by the next cycle, `exc_kind_i` is always one of the four defined kinds, and the data inputs are stable whenever a request or return is asserted. The stimulus changes inputs only at the falling edge and holds each request for exactly one cycle. It sets `sr_i` explicitly for every scenario, so each request sees either a clear or a set block bit as that scenario intends.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  typedef enum logic [1:0] {
    EXC_PG_WRITE = 2'd0,
    EXC_MISS_RD  = 2'd1,
    EXC_MISS_WR  = 2'd2,
    EXC_PROT     = 2'd3
  } exc_kind_e;

  localparam int SR_MD_BIT = 30;
  localparam int SR_RB_BIT = 29;
  localparam int SR_BL_BIT = 28;
endpackage

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
  import exc_seq_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12,
  parameter logic [CODE_W-1:0] CODE_PG_WRITE = 12'h080,
  parameter logic [CODE_W-1:0] CODE_MISS_RD  = 12'h040,
  parameter logic [CODE_W-1:0] CODE_MISS_WR  = 12'h060,
  parameter logic [CODE_W-1:0] CODE_PROT     = 12'h0A0,
  parameter logic [XLEN-1:0]   OFS_GENERAL   = 32'h0000_0100,
  parameter logic [XLEN-1:0]   OFS_MISS      = 32'h0000_0400
) (
  input  exc_kind_e         kind_i,
  input  logic [XLEN-1:0]   vbr_i,
  output logic [CODE_W-1:0] code_o,
  output logic [XLEN-1:0]   target_o
);
  logic [XLEN-1:0] ofs;

  always_comb begin
    unique case (kind_i)
      EXC_PG_WRITE: begin code_o = CODE_PG_WRITE; ofs = OFS_GENERAL; end
      EXC_MISS_RD:  begin code_o = CODE_MISS_RD;  ofs = OFS_MISS;    end
      EXC_MISS_WR:  begin code_o = CODE_MISS_WR;  ofs = OFS_MISS;    end
      default:      begin code_o = CODE_PROT;     ofs = OFS_GENERAL; end
    endcase
  end

  assign target_o = vbr_i + ofs;  // wraps modulo 2^XLEN
endmodule

// File: rtl/exc_save_regs.sv
module exc_save_regs #(
  parameter int XLEN    = 32,
  parameter int VPN_LSB = 10,
  parameter int WAY_W   = 2,
  parameter int CODE_W  = 12,
  localparam int VPN_W  = XLEN - VPN_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [XLEN-1:0]   va_i,
  input  logic [XLEN-1:0]   ret_pc_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [WAY_W-1:0]  way_i,
  output logic [VPN_W-1:0]  vpn_o,
  output logic [XLEN-1:0]   tea_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [CODE_W-1:0] cause_o,
  output logic [WAY_W-1:0]  rc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vpn_o   <= '0;
      tea_o   <= '0;
      spc_o   <= '0;
      ssr_o   <= '0;
      cause_o <= '0;
      rc_o    <= '0;
    end else if (capture_i) begin
      vpn_o   <= va_i[XLEN-1:VPN_LSB];
      tea_o   <= va_i;
      spc_o   <= ret_pc_i;
      ssr_o   <= sr_i;
      cause_o <= code_i;
      rc_o    <= way_i;
    end
  end

  p_tea_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> tea_o == $past(va_i));
  p_vpn_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> vpn_o == $past(va_i[XLEN-1:VPN_LSB]));
  p_ssr_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> ssr_o == $past(sr_i));
  p_rc_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> rc_o == $past(way_i));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(tea_o) && $stable(spc_o) && $stable(ssr_o)
                   && $stable(cause_o) && $stable(rc_o) && $stable(vpn_o));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int VPN_LSB = 10,
  parameter int WAY_W   = 2,
  parameter int CODE_W  = 12,
  localparam int VPN_W  = XLEN - VPN_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_req_i,
  input  logic [1:0]        exc_kind_i,
  input  logic [XLEN-1:0]   fault_va_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              in_dslot_i,
  input  logic [XLEN-1:0]   branch_pc_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic [WAY_W-1:0]  way_i,
  input  logic              rte_i,
  output logic              redirect_o,
  output logic [XLEN-1:0]   target_o,
  output logic              sr_we_o,
  output logic [XLEN-1:0]   sr_next_o,
  output logic [VPN_W-1:0]  vpn_o,
  output logic [XLEN-1:0]   tea_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [CODE_W-1:0] cause_o,
  output logic [WAY_W-1:0]  rc_o
);
  localparam logic [XLEN-1:0] ENTRY_SET =
    (XLEN'(1) << SR_MD_BIT) | (XLEN'(1) << SR_RB_BIT) | (XLEN'(1) << SR_BL_BIT);

  logic              accept;
  logic [XLEN-1:0]   ret_pc;
  logic [XLEN-1:0]   vec_target;
  logic [CODE_W-1:0] vec_code;

  // return wins over a simultaneous request; BL masks new entries
  assign accept = exc_req_i && !rte_i && !sr_i[SR_BL_BIT];
  assign ret_pc = in_dslot_i ? branch_pc_i : pc_i;

  exc_vec_sel #(.XLEN(XLEN), .CODE_W(CODE_W)) u_vec (
    .kind_i   (exc_kind_e'(exc_kind_i)),
    .vbr_i    (vbr_i),
    .code_o   (vec_code),
    .target_o (vec_target)
  );

  exc_save_regs #(.XLEN(XLEN), .VPN_LSB(VPN_LSB), .WAY_W(WAY_W), .CODE_W(CODE_W)) u_save (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (accept),
    .va_i      (fault_va_i),
    .ret_pc_i  (ret_pc),
    .sr_i      (sr_i),
    .code_i    (vec_code),
    .way_i     (way_i),
    .vpn_o     (vpn_o),
    .tea_o     (tea_o),
    .spc_o     (spc_o),
    .ssr_o     (ssr_o),
    .cause_o   (cause_o),
    .rc_o      (rc_o)
  );

  always_comb begin
    redirect_o = 1'b0;
    sr_we_o    = 1'b0;
    target_o   = vec_target;
    sr_next_o  = sr_i;
    if (rte_i) begin
      redirect_o = 1'b1;
      sr_we_o    = 1'b1;
      target_o   = spc_o;
      sr_next_o  = ssr_o;
    end else if (accept) begin
      redirect_o = 1'b1;
      sr_we_o    = 1'b1;
      sr_next_o  = sr_i | ENTRY_SET;
    end
  end

  p_entry_bits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> sr_we_o && sr_next_o[SR_MD_BIT] && sr_next_o[SR_BL_BIT] && sr_next_o[SR_RB_BIT]);
  p_spc_select_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> spc_o == ($past(in_dslot_i) ? $past(branch_pc_i) : $past(pc_i)));
  p_blocked_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_i && sr_i[SR_BL_BIT] && !rte_i) |-> !redirect_o && !sr_we_o);
  p_rte_restore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rte_i |-> redirect_o && target_o == spc_o && sr_next_o == ssr_o);
  p_rte_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rte_i |=> $stable(spc_o) && $stable(ssr_o));
endmodule

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, dslot = 1'b0, rte = 1'b0;
  logic [1:0]  kind = '0, way = '0;
  logic [31:0] va = '0, pc = '0, bpc = '0, sr = '0, vbr = '0;
  logic        redirect, sr_we;
  logic [31:0] target, sr_next, tea, spc, ssr;
  logic [21:0] vpn;
  logic [11:0] cause;
  logic [1:0]  rc;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  exc_entry_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .exc_req_i(req), .exc_kind_i(kind),
    .fault_va_i(va), .pc_i(pc), .in_dslot_i(dslot), .branch_pc_i(bpc),
    .sr_i(sr), .vbr_i(vbr), .way_i(way), .rte_i(rte),
    .redirect_o(redirect), .target_o(target), .sr_we_o(sr_we), .sr_next_o(sr_next),
    .vpn_o(vpn), .tea_o(tea), .spc_o(spc), .ssr_o(ssr), .cause_o(cause), .rc_o(rc)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one accepted request, checks combinational outputs then saved state
  task automatic take(logic [1:0] k, logic [31:0] a, logic [31:0] p, logic ds,
                      logic [31:0] b, logic [31:0] s, logic [31:0] v, logic [1:0] w,
                      logic [11:0] exp_code, logic [31:0] exp_ofs);
    @(negedge clk);
    kind = k; va = a; pc = p; dslot = ds; bpc = b; sr = s; vbr = v; way = w; req = 1'b1;
    #1;
    chk("R7 redirect", 32'(redirect), 32'd1);
    chk("R7 target", target, v + exp_ofs);
    chk("R5 sr_we", 32'(sr_we), 32'd1);
    chk("R5 sr_next", sr_next, s | 32'h7000_0000);
    @(negedge clk);
    req = 1'b0;
    chk("R2 tea", tea, a);
    chk("R2 vpn", 32'(vpn), a >> 10);
    chk("R3 cause", 32'(cause), 32'(exp_code));
    chk("R4 spc", spc, ds ? b : p);
    chk("R5 ssr", ssr, s);
    chk("R6 rc", 32'(rc), 32'(w));
  endtask

  task automatic t_reset;
    chk("R1 tea", tea, 0); chk("R1 spc", spc, 0); chk("R1 ssr", ssr, 0);
    chk("R1 vpn", 32'(vpn), 0); chk("R1 cause", 32'(cause), 0); chk("R1 rc", 32'(rc), 0);
    chk("R1 redirect", 32'(redirect), 0); chk("R1 sr_we", 32'(sr_we), 0);
  endtask

  task automatic t_blocked;
    logic [31:0] old_tea = tea, old_ssr = ssr;
    logic [11:0] old_cause = cause;
    @(negedge clk);
    kind = 2'd1; va = 32'hDEAD_BEEF; sr = 32'h1000_0000; req = 1'b1;
    #1;
    chk("R8 redirect", 32'(redirect), 0);
    chk("R8 sr_we", 32'(sr_we), 0);
    @(negedge clk);
    req = 1'b0;
    chk("R8 tea", tea, old_tea);
    chk("R8 ssr", ssr, old_ssr);
    chk("R8 cause", 32'(cause), 32'(old_cause));
  endtask

  task automatic t_rte;
    logic [31:0] old_spc = spc, old_ssr = ssr, old_tea = tea;
    @(negedge clk);
    rte = 1'b1; req = 1'b1; sr = 32'h7000_0000; va = 32'h5555_0000;
    #1;
    chk("R9 redirect", 32'(redirect), 1);
    chk("R9 target", target, old_spc);
    chk("R9 sr_we", 32'(sr_we), 1);
    chk("R9 sr_next", sr_next, old_ssr);
    @(negedge clk);
    rte = 1'b0; req = 1'b0;
    chk("R9 spc kept", spc, old_spc);
    chk("R9 tea kept", tea, old_tea);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    take(2'd0, 32'h1234_5ABC, 32'h8000_1000, 1'b0, 32'h0, 32'h0000_00F0,
         32'h8C00_0000, 2'd2, 12'h080, 32'h100);
    take(2'd1, 32'h0040_0C00, 32'h8000_2002, 1'b1, 32'h8000_1FFE, 32'h4000_0001,
         32'h8C00_0000, 2'd1, 12'h040, 32'h400);
    take(2'd2, 32'hFFFF_FC00, 32'h0000_0010, 1'b0, 32'h0000_000E, 32'h0,
         32'hA000_0000, 2'd3, 12'h060, 32'h400);
    take(2'd3, 32'h0000_03FF, 32'h0000_0100, 1'b1, 32'h0000_00FC, 32'h8000_0003,
         32'hFFFF_FF80, 2'd0, 12'h0A0, 32'h100);  // vector wraps past 2^32
    t_blocked();
    t_rte();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule